// File: doc/BRIEF.md
# Configurable Synchronous Serial Frame Receiver

This block takes a synchronous serial stream made of a bit clock, a frame sync and a data line, and turns it into parallel words. A rising edge on the frame sync opens a frame. The block then collects a programmed number of words, each of a programmed bit length, in either bit order. Every finished word goes out on a one-cycle valid/data port. A size tag with the word says whether downstream transfers should move it as a byte, a half-word or a 32-bit word.

Everything runs on one system clock. The serial clock is treated as a sampled signal, and each rising edge of it gives a one-cycle bit strobe. At the start of each frame the block drives a frame sync output pulse of programmable length. A loopback control routes the local transmit clock, sync and data back into the receive path, so the path can be tested without external wiring. Configuration is captured when a frame starts. Changes made while a frame is running take effect from the next frame.

Top module: `ssr_frame_rx`

## Requirements
- R1: After reset, `word_valid` and `fs_out` are 0 and `word_data` is 0.
- R2: With `cfg_wlen` = N (N from 1 to 31), every word holds N+1 received bits, right-aligned at bit 0, and every bit above bit N is 0.
- R3: With `cfg_msb_first` = 1, the first bit received after the start is the word's most significant bit (bit N). With it at 0, the first bit received is bit 0.
- R4: `word_size` is 0 (byte) for N ≤ 7, 1 (half-word) for N from 8 to 15, and 2 (32-bit word) for N ≥ 16. The value 3 never appears.
- R5: A rising edge of the frame sync, sampled on a serial clock rising edge, starts a frame. Data bits begin at the next serial clock rising edge. Exactly `cfg_words`+1 words are then delivered, and the block goes back to waiting for a start.
- R6: `word_valid` is high for exactly one system clock. That clock is the one right after the serial clock edge that carried the word's last bit.
- R7: `fs_out` rises in the clock after a frame start. It stays high for (`cfg_fs_lo` + 16·`cfg_fs_hi` + 1) serial clock periods.
- R8: With `cfg_wlen` = 0 (an illegal length), a sync edge starts no frame: no word is delivered and `fs_out` stays low.
- R9: A frame sync rising edge that arrives while a frame is in progress is ignored. The frame still delivers exactly its own words.
- R10: A change to any configuration input during a frame does not affect that frame's words.
- R11: With `cfg_loop` = 1, the receive path uses `tx_clk_pin`, `tx_fs_pin` and `tx_dat_pin`, and the receive pins are ignored. With `cfg_loop` = 0, only the receive pins are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wlen | input | 5 | Word length minus one (0 is illegal) |
| cfg_msb_first | input | 1 | 1: most significant bit arrives first |
| cfg_words | input | 4 | Words per frame minus one |
| cfg_fs_lo | input | 4 | Sync pulse length, low part |
| cfg_fs_hi | input | 4 | Sync pulse length, extension (×16) |
| cfg_loop | input | 1 | 1: receive from the local transmit signals |
| rx_clk_pin | input | 1 | External serial clock |
| rx_fs_pin | input | 1 | External frame sync |
| rx_dat_pin | input | 1 | External serial data |
| tx_clk_pin | input | 1 | Local transmit clock (loopback source) |
| tx_fs_pin | input | 1 | Local transmit sync (loopback source) |
| tx_dat_pin | input | 1 | Local transmit data (loopback source) |
| fs_out | output | 1 | Generated receive frame sync pulse |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 32 | Completed word, zero-extended |
| word_size | output | 2 | Transfer size: 0 byte, 1 half-word, 2 word |

## Verification
Frames are sent with word lengths at each size boundary (8, 9, 16, 17, 32 bits) and in both bit orders. The data patterns are asymmetric, so a bit-reversed or shifted word cannot match its expected value. Other frames carry a second sync edge in mid-frame, flip the bit order in mid-frame, or use the illegal zero length, which should produce no frame at all. These separate "ignored" from "restarted" and "latched" from "live". A loopback frame is driven only on the transmit pins while the receive pins stay quiet, which shows the source is selected correctly. The sync pulse width is measured for several low/extension splits, including the largest setting.

// File: rtl/ssr_rx_pkg.sv
// Shared widths and the transfer size type for the serial frame receiver.
// Assumes a 32-bit maximum word length.
package ssr_rx_pkg;
    localparam int MAX_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    // Maps a length-minus-one code to a transfer size.
    function automatic xfer_size_e size_of(input logic [4:0] len_m1);
        if (len_m1 <= 5'd7)       return SZ_BYTE;
        else if (len_m1 <= 5'd15) return SZ_HALF;
        else                      return SZ_WORD;
    endfunction
endpackage

// File: rtl/ssr_pin_sel.sv
// Loopback source selection and serial clock edge detection.
// Produces a one-cycle strobe on each rising edge of the selected serial clock,
// along with the selected sync and data levels, which are valid while the
// strobe is high. Assumes all pins are already synchronous to clk.
module ssr_pin_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic ext_clk,
    input  logic ext_fs,
    input  logic ext_dat,
    input  logic lcl_clk,
    input  logic lcl_fs,
    input  logic lcl_dat,
    output logic bit_stb,
    output logic sel_fs,
    output logic sel_dat
);
    logic sel_clk;
    logic clk_d;

    // Picks the pin set according to the loopback control.
    always_comb begin
        sel_clk = loop_en ? lcl_clk : ext_clk;
        sel_fs  = loop_en ? lcl_fs  : ext_fs;
        sel_dat = loop_en ? lcl_dat : ext_dat;
    end

    // Remembers the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_d <= 1'b1;
        else        clk_d <= sel_clk;
    end

    assign bit_stb = sel_clk & ~clk_d;
endmodule

// File: rtl/ssr_frame_ctl.sv
// Frame sequencing: start detection, configuration capture, bit and word
// counting, and the generated sync pulse. Assumes bit_stb is one cycle wide.
module ssr_frame_ctl #(
    parameter int LEN_W = 5,
    parameter int NB_W  = 4,
    parameter int FSL_W = 4,
    parameter int FSX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             fs_lvl,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_msb,
    input  logic [NB_W-1:0]  cfg_nb,
    input  logic [FSL_W-1:0] cfg_fsl,
    input  logic [FSX_W-1:0] cfg_fsx,
    output logic             take_bit,
    output logic             last_bit,
    output logic [LEN_W-1:0] bit_idx,
    output logic [LEN_W-1:0] len_l,
    output logic             msb_l,
    output logic             fs_pulse
);
    localparam int SC_W = FSL_W + FSX_W + 1;

    logic             active;
    logic             fs_prev;
    logic [NB_W-1:0]  word_idx;
    logic [NB_W-1:0]  nb_l;
    logic [SC_W-1:0]  sync_cnt;
    logic [SC_W-1:0]  sync_len;
    logic             start;

    // Pulse length in serial periods: low + 16*extension + 1.
    assign sync_len = SC_W'(cfg_fsl) + (SC_W'(cfg_fsx) << 4) + SC_W'(1);
    assign start    = bit_stb & fs_lvl & ~fs_prev & ~active & (cfg_len != '0);
    assign take_bit = bit_stb & active;
    assign last_bit = (bit_idx == len_l);
    assign fs_pulse = (sync_cnt != '0);

    // Tracks the sync level seen at each serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       fs_prev <= 1'b0;
        else if (bit_stb) fs_prev <= fs_lvl;
    end

    // Runs the frame: captures config, steps bit and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            bit_idx  <= '0;
            word_idx <= '0;
            len_l    <= '0;
            nb_l     <= '0;
            msb_l    <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            bit_idx  <= '0;
            word_idx <= '0;
            len_l    <= cfg_len;
            nb_l     <= cfg_nb;
            msb_l    <= cfg_msb;
        end else if (take_bit) begin
            if (last_bit) begin
                bit_idx <= '0;
                if (word_idx == nb_l) active   <= 1'b0;
                else                  word_idx <= word_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Counts down the generated sync pulse in serial periods.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sync_cnt <= '0;
        else if (start)                     sync_cnt <= sync_len;
        else if (bit_stb && sync_cnt != '0) sync_cnt <= sync_cnt - 1'b1;
    end
endmodule

// File: rtl/ssr_word_asm.sv
// Word assembly in either bit order, right-aligned and zero-extended, plus
// the registered output port. Assumes bit_idx restarts at 0 for every word.
module ssr_word_asm
    import ssr_rx_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int DW    = MAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_bit,
    input  logic             last_bit,
    input  logic             din,
    input  logic             msb_first,
    input  logic [LEN_W-1:0] bit_idx,
    input  logic [LEN_W-1:0] len_m1,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic [1:0]       out_size
);
    logic [DW-1:0] shreg;
    logic [DW-1:0] base;
    logic [DW-1:0] nxt;

    // Forms the word value including the bit arriving now.
    always_comb begin
        base = (bit_idx == '0) ? '0 : shreg;
        if (msb_first) nxt = {base[DW-2:0], din};
        else           nxt = base | (DW'(din) << bit_idx);
    end

    // Holds the partial word between serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (take_bit) shreg <= nxt;
    end

    // Presents each completed word for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_size  <= SZ_BYTE;
        end else begin
            out_valid <= take_bit & last_bit;
            if (take_bit && last_bit) begin
                out_data <= nxt;
                out_size <= size_of(len_m1);
            end
        end
    end
endmodule

// File: rtl/ssr_frame_rx.sv
// Top level of the synchronous serial frame receiver: pin selection, frame
// control and word assembly. Assumes every pin is synchronous to clk and
// that the serial clock runs at no more than half the system clock.
module ssr_frame_rx
    import ssr_rx_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int NB_W  = 4,
    parameter int FSL_W = 4,
    parameter int FSX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_wlen,
    input  logic             cfg_msb_first,
    input  logic [NB_W-1:0]  cfg_words,
    input  logic [FSL_W-1:0] cfg_fs_lo,
    input  logic [FSX_W-1:0] cfg_fs_hi,
    input  logic             cfg_loop,
    input  logic             rx_clk_pin,
    input  logic             rx_fs_pin,
    input  logic             rx_dat_pin,
    input  logic             tx_clk_pin,
    input  logic             tx_fs_pin,
    input  logic             tx_dat_pin,
    output logic             fs_out,
    output logic             word_valid,
    output logic [MAX_W-1:0] word_data,
    output logic [1:0]       word_size
);
    logic             bit_stb, sel_fs, sel_dat;
    logic             take_bit, last_bit, msb_l;
    logic [LEN_W-1:0] bit_idx, len_l;

    ssr_pin_sel u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_en (cfg_loop),
        .ext_clk (rx_clk_pin),
        .ext_fs  (rx_fs_pin),
        .ext_dat (rx_dat_pin),
        .lcl_clk (tx_clk_pin),
        .lcl_fs  (tx_fs_pin),
        .lcl_dat (tx_dat_pin),
        .bit_stb (bit_stb),
        .sel_fs  (sel_fs),
        .sel_dat (sel_dat)
    );

    ssr_frame_ctl #(
        .LEN_W (LEN_W),
        .NB_W  (NB_W),
        .FSL_W (FSL_W),
        .FSX_W (FSX_W)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .fs_lvl   (sel_fs),
        .cfg_len  (cfg_wlen),
        .cfg_msb  (cfg_msb_first),
        .cfg_nb   (cfg_words),
        .cfg_fsl  (cfg_fs_lo),
        .cfg_fsx  (cfg_fs_hi),
        .take_bit (take_bit),
        .last_bit (last_bit),
        .bit_idx  (bit_idx),
        .len_l    (len_l),
        .msb_l    (msb_l),
        .fs_pulse (fs_out)
    );

    ssr_word_asm #(
        .LEN_W (LEN_W),
        .DW    (MAX_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_bit  (take_bit),
        .last_bit  (last_bit),
        .din       (sel_dat),
        .msb_first (msb_l),
        .bit_idx   (bit_idx),
        .len_m1    (len_l),
        .out_valid (word_valid),
        .out_data  (word_data),
        .out_size  (word_size)
    );
endmodule

// File: rtl/ssr_frame_rx_chk.sv
// Property checker for the serial frame receiver, attached by bind.
module ssr_frame_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic [31:0] word_data,
    input logic [1:0]  word_size,
    input logic        fs_out,
    input logic        bit_stb,
    input logic        take_bit
);
    // R6: the valid strobe lasts one cycle.
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R6: a word appears only after a bit was taken on a serial edge.
    assert_valid_after_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> $past(take_bit));

    // R4: the size code 3 never appears.
    assert_size_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> word_size != 2'd3);

    // R2: a byte-size word has zero upper bits.
    assert_byte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_size == 2'd0) |-> word_data[31:8] == 24'd0);

    // R2: a half-word-size word has zero upper bits.
    assert_half_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_size == 2'd1) |-> word_data[31:16] == 16'd0);

    // R7: the sync pulse starts and ends only on a serial edge.
    assert_fs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fs_out) || $fell(fs_out)) |-> $past(bit_stb));
endmodule

bind ssr_frame_rx ssr_frame_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_size  (word_size),
    .fs_out     (fs_out),
    .bit_stb    (bit_stb),
    .take_bit   (take_bit)
);

// File: tb/tb_ssr_frame_rx.sv
module tb_ssr_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_wlen = 5'd7;
    logic        cfg_msb_first = 1'b0;
    logic [3:0]  cfg_words = 4'd0;
    logic [3:0]  cfg_fs_lo = 4'd0;
    logic [3:0]  cfg_fs_hi = 4'd0;
    logic        cfg_loop = 1'b0;
    logic        rx_clk_pin = 1'b0, rx_fs_pin = 1'b0, rx_dat_pin = 1'b0;
    logic        tx_clk_pin = 1'b0, tx_fs_pin = 1'b0, tx_dat_pin = 1'b0;
    logic        fs_out, word_valid;
    logic [31:0] word_data;
    logic [1:0]  word_size;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    int exp_pulse = 0;
    int hi_cnt    = 0;

    typedef struct { logic [31:0] data; logic [1:0] size; string tag; } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    ssr_frame_rx dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wlen(cfg_wlen), .cfg_msb_first(cfg_msb_first), .cfg_words(cfg_words),
        .cfg_fs_lo(cfg_fs_lo), .cfg_fs_hi(cfg_fs_hi), .cfg_loop(cfg_loop),
        .rx_clk_pin(rx_clk_pin), .rx_fs_pin(rx_fs_pin), .rx_dat_pin(rx_dat_pin),
        .tx_clk_pin(tx_clk_pin), .tx_fs_pin(tx_fs_pin), .tx_dat_pin(tx_dat_pin),
        .fs_out(fs_out), .word_valid(word_valid), .word_data(word_data),
        .word_size(word_size)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One serial period of 4 system clocks; drives the pin set picked by loop.
    // The unused set gets noise on data and sync, with its clock held low.
    task automatic bitp(input logic fs, input logic d);
        for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            if (cfg_loop) begin
                tx_clk_pin = h[0]; tx_fs_pin = fs; tx_dat_pin = d;
                rx_clk_pin = 1'b0; rx_fs_pin = ~fs; rx_dat_pin = ~d;
            end else begin
                rx_clk_pin = h[0]; rx_fs_pin = fs; rx_dat_pin = d;
                tx_clk_pin = 1'b0; tx_fs_pin = ~fs; tx_dat_pin = ~d;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic [1:0] size_exp(input logic [4:0] n);
        if (n <= 5'd7) return 2'd0;
        if (n <= 5'd15) return 2'd1;
        return 2'd2;
    endfunction

    // Driver: sends one frame and pushes the expected words.
    // mid_fs adds a second sync rise inside word 0 (R9).
    // flip inverts the bit order input during word 0 (R10).
    task automatic send_frame(input logic [4:0] n, input logic msb, input logic [3:0] nb,
                              input logic [3:0] fl, input logic [3:0] fx,
                              input logic [31:0] w [4], input bit mid_fs,
                              input bit flip, input string tag);
        logic [32:0] mask;
        cfg_wlen = n; cfg_msb_first = msb; cfg_words = nb;
        cfg_fs_lo = fl; cfg_fs_hi = fx;
        mask = (33'd1 << (n + 1)) - 33'd1;
        exp_pulse = (n == 0) ? 0 : 4 * (int'(fl) + 16 * int'(fx) + 1);
        bitp(1'b0, 1'b0);
        bitp(1'b1, 1'b0);
        for (int wi = 0; wi <= int'(nb); wi++) begin
            logic [31:0] word;
            word = w[wi % 4] & mask[31:0];
            if (n != 0) exp_q.push_back('{word, size_exp(n), tag});
            for (int b = 0; b <= int'(n); b++) begin
                int idx;
                logic fsv;
                idx = msb ? int'(n) - b : b;
                fsv = mid_fs && wi == 0 && b == 2;
                if (flip && wi == 0 && b == 1) begin
                    cfg_msb_first = ~msb;
                    cfg_wlen = 5'd3;
                    cfg_words = 4'd0;
                end
                bitp(fsv, w[wi % 4][idx]);
            end
        end
        for (int t = 0; t < 260; t++) bitp(1'b0, 1'b0);
        check(exp_q.size() == 0, {tag, " R5 word count"}, 32'(exp_q.size()), 32'd0);
    endtask

    // Monitor: compares each delivered word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R8/R9 unexpected word", word_data, 32'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(word_data == e.data, {e.tag, " data"}, word_data, e.data);
                check(word_size == e.size, {e.tag, " R4 size"}, 32'(word_size), 32'(e.size));
            end
        end
    end

    // Monitor: measures the sync pulse width in system clocks (R7, R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (fs_out) hi_cnt++;
            else if (hi_cnt != 0) begin
                check(hi_cnt == exp_pulse, "R7 sync pulse width", 32'(hi_cnt), 32'(exp_pulse));
                hi_cnt = 0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w [4];
        repeat (3) @(negedge clk);
        // R1: reset values.
        check(word_valid == 1'b0, "R1 valid", 32'(word_valid), 32'd0);
        check(fs_out == 1'b0, "R1 fs_out", 32'(fs_out), 32'd0);
        check(word_data == 32'd0, "R1 data", word_data, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        w = '{32'h0000_00B4, 32'h0000_0039, 32'h0000_00E1, 32'h0000_0072};
        // R2 R3 R5: 8-bit words, LSB first, 3 words.
        send_frame(5'd7, 1'b0, 4'd2, 4'd3, 4'd0, w, 0, 0, "R3 lsb 8b");
        // R3: 8-bit words, MSB first.
        send_frame(5'd7, 1'b1, 4'd1, 4'd0, 4'd0, w, 0, 0, "R3 msb 8b");
        w = '{32'h0000_01A5, 32'h0000_B3C2, 32'h0001_7E0F, 32'hC35A_9617};
        // R4: 9-bit words give half-word size.
        send_frame(5'd8, 1'b1, 4'd0, 4'd5, 4'd1, w, 0, 0, "R4 9b");
        // R4: 16-bit words stay half-word; the upper bits of the pattern are masked.
        send_frame(5'd15, 1'b0, 4'd1, 4'd15, 4'd0, w, 0, 0, "R2 16b");
        // R4: 17-bit words give 32-bit size.
        send_frame(5'd16, 1'b1, 4'd2, 4'd2, 4'd2, w, 0, 0, "R4 17b");
        // R2: full 32-bit words, largest sync pulse.
        send_frame(5'd31, 1'b0, 4'd3, 4'd15, 4'd15, w, 0, 0, "R2 32b");
        w = '{32'h0000_0006, 32'h0000_0009, 32'h0000_0003, 32'h0000_000C};
        // R8: illegal zero length delivers nothing.
        send_frame(5'd0, 1'b0, 4'd1, 4'd2, 4'd0, w, 0, 0, "R8 len0");
        w = '{32'h0000_00C6, 32'h0000_005D, 32'h0000_00E1, 32'h0000_0072};
        // R9: sync rise inside a frame is ignored.
        send_frame(5'd7, 1'b1, 4'd1, 4'd1, 4'd0, w, 1, 0, "R9 mid sync");
        // R10: config changed inside a frame does not affect it.
        send_frame(5'd7, 1'b1, 4'd1, 4'd0, 4'd0, w, 0, 1, "R10 cfg change");
        // R11: loopback uses the transmit pins only.
        cfg_loop = 1'b1;
        send_frame(5'd11, 1'b0, 4'd1, 4'd4, 4'd0, w, 0, 0, "R11 loop");
        cfg_loop = 1'b0;
        // R11: back on the receive pins with the transmit pins carrying noise.
        send_frame(5'd7, 1'b0, 4'd0, 4'd0, 4'd0, w, 0, 0, "R11 ext");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule